// File: doc/BRIEF.md
# PCI Function Event Report Queue

This block collects events about PCI functions from three producers and holds them in order until a consumer collects them. The first producer reports address-translation faults. The second reports interrupt-delivery faults. The third produces hot-plug and hot-unplug activity. A consumer watches a have-event level, then pulses a pop request. One cycle later it receives a status and a formatted report record for the oldest event. The layout of that record depends on the event class. Each event that is accepted into the queue raises a one-cycle channel-report notification.

When producers request in the same cycle, a fixed-priority arbiter takes one event per cycle. A small state machine turns one hot-plug or hot-unplug request into the right sequence of availability events. Its states are:

- `S_IDLE`: waits for a request.
- `S_ADD_STBY`: emits reserved-to-standby.
- `S_ADD_CFG`: emits standby-to-configured.
- `S_DEL_CFG`: emits configured-to-standby/reserved.
- `S_DEL_RES`: emits standby-to-reserved.

Its transitions are:

- `S_IDLE`→`S_ADD_STBY` on a plug request.
- `S_IDLE`→`S_DEL_CFG` on an unplug request when the function is configured.
- `S_IDLE`→`S_DEL_RES` on an unplug request when the function is not configured.
- `S_ADD_STBY`→`S_ADD_CFG`, `S_ADD_CFG`→`S_IDLE`, `S_DEL_CFG`→`S_DEL_RES` and `S_DEL_RES`→`S_IDLE`, each taken on the arbiter grant.

Top module: `fn_event_queue`

## Requirements
- R1: After reset the queue is empty and `have_event` is 0. `have_event` is 1 exactly when at least one event is stored.
- R2: A pop on an empty queue gives, on the next cycle, `pop_valid`=1, `pop_status`=1, `rpt_class`=0, `rpt_len`=0 and an all-zero record.
- R3: A pop on a non-empty queue gives, on the next cycle, `pop_valid`=1 and `pop_status`=0. It removes the oldest entry, so events leave in arrival order.
- R4: Class 1 is an error event. Its record is 22 bytes long (`rpt_len`=22). Byte 0 sits in bits 175:168, and every field is written most significant byte first. The fields are: function ID (4 bytes), function handle (4), error qualifier (4), fault address (8) and error code (2).
- R5: Class 2 is an availability event. Its record holds function ID (4 bytes), function handle (4) and error code (2), followed by zeros, and `rpt_len`=10.
- R6: `crw_notify` is high for exactly one cycle, in the cycle after each event is accepted into the queue. It stays low for events that are dropped.
- R7: When requests arrive together, the translation port is served first, then the interrupt port, then the plug sequencer. `xlt_ack` and `irq_ack` mark the cycle in which the port's event is taken, and a port holds its request until it sees its ack.
- R8: A plug request queues two class-2 events in order: code 0x0301 (reserved-to-standby), then code 0x0302 (standby-to-configured). Both carry the latched handle and ID.
- R9: An unplug request queues code 0x0303 (configured-to-standby/reserved) only when `plug_configured`=1. It then always queues code 0x0304 (standby-to-reserved).
- R10: The queue holds 16 entries. An event that arrives while the queue is full is dropped and sets `overflow`, which stays set until reset.
- R11: A translation event whose class is neither 1 nor 2 is acknowledged but not stored. It sets `proto_err`, which stays set until reset, and raises no notification.
- R12: Interrupt-port events are stored as class 1 with a function handle of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlt_req | input | 1 | Translation event request |
| xlt_class | input | 2 | Translation event class |
| xlt_pec | input | 16 | Translation error code |
| xlt_fh | input | 32 | Translation function handle |
| xlt_fid | input | 32 | Translation function ID |
| xlt_addr | input | 64 | Translation fault address |
| xlt_qual | input | 32 | Translation error qualifier |
| xlt_ack | output | 1 | Translation event taken this cycle |
| irq_req | input | 1 | Interrupt error request |
| irq_pec | input | 16 | Interrupt error code |
| irq_fid | input | 32 | Interrupt function ID |
| irq_addr | input | 64 | Interrupt fault address |
| irq_qual | input | 32 | Interrupt error qualifier |
| irq_ack | output | 1 | Interrupt event taken this cycle |
| plug_req | input | 1 | Start a plug or unplug sequence |
| plug_remove | input | 1 | 1 = unplug, 0 = plug |
| plug_configured | input | 1 | Function currently configured (unplug) |
| plug_fh | input | 32 | Function handle for the sequence |
| plug_fid | input | 32 | Function ID for the sequence |
| plug_busy | output | 1 | Sequencer active; requests ignored |
| pop_req | input | 1 | Pop the oldest event |
| have_event | output | 1 | Queue not empty |
| pop_valid | output | 1 | Pop response valid |
| pop_status | output | 1 | 0 = event returned, 1 = no event |
| rpt_class | output | 2 | Class of returned event |
| rpt_len | output | 5 | Record length in bytes |
| rpt_rec | output | 176 | Report record, byte 0 in the top bits |
| crw_notify | output | 1 | Channel-report notification pulse |
| overflow | output | 1 | Sticky: event dropped because the queue was full |
| proto_err | output | 1 | Sticky: invalid event class seen |

## Verification
The bench first pops an empty queue. A design that treated an empty pop as a success would return status 0 and stale record data. It then sends all three producers in one cycle and drains the queue. A wrong priority order, or a plug sequencer that advanced without a grant, shows up as reordered or missing events in the pops. Unplug is run both with and without the configured flag, which catches a sequencer that always or never emits the configured-to-standby event. The queue is filled to sixteen entries and one more event is sent. The bench checks that this event is dropped, that it raises no notification and that the overflow flag stays set. An invalid class is checked the same way, so a design that stored it would leave `have_event` set.

// File: rtl/evq_pkg.sv
package evq_pkg;
    localparam int PEC_W  = 16;
    localparam int FH_W   = 32;
    localparam int FID_W  = 32;
    localparam int ADDR_W = 64;
    localparam int QUAL_W = 32;
    localparam int CLS_W  = 2;
    localparam int REC_W  = FID_W + FH_W + QUAL_W + ADDR_W + PEC_W;
    localparam int AVL_W  = FID_W + FH_W + PEC_W;
    localparam int LEN_W  = 5;

    localparam logic [CLS_W-1:0] CLS_ERR   = 2'd1;
    localparam logic [CLS_W-1:0] CLS_AVAIL = 2'd2;

    localparam logic [PEC_W-1:0] PEC_RES_TO_STBY    = 16'h0301;
    localparam logic [PEC_W-1:0] PEC_STBY_TO_CFG    = 16'h0302;
    localparam logic [PEC_W-1:0] PEC_CFG_TO_STBYRES = 16'h0303;
    localparam logic [PEC_W-1:0] PEC_STBY_TO_RES    = 16'h0304;

    typedef struct packed {
        logic [CLS_W-1:0]  cls;
        logic [PEC_W-1:0]  pec;
        logic [FH_W-1:0]   fh;
        logic [FID_W-1:0]  fid;
        logic [ADDR_W-1:0] addr;
        logic [QUAL_W-1:0] qual;
    } evq_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADD_STBY,
        S_ADD_CFG,
        S_DEL_CFG,
        S_DEL_RES
    } plug_state_t;
endpackage

// File: rtl/evq_arbiter.sv
module evq_arbiter #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

    // R7: at most one producer served per cycle, and only a requester
    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & ~req) == '0));
endmodule

// File: rtl/evq_plug_seq.sv
module evq_plug_seq
    import evq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              remove,
    input  logic              configured,
    input  logic [FH_W-1:0]   fh_in,
    input  logic [FID_W-1:0]  fid_in,
    input  logic              gnt,
    output logic              ev_req,
    output evq_entry_t        ev,
    output logic              busy
);
    plug_state_t state, state_nx;
    logic [FH_W-1:0]  fh_q;
    logic [FID_W-1:0] fid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            fh_q  <= '0;
            fid_q <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && start) begin
                fh_q  <= fh_in;
                fid_q <= fid_in;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (!remove)        state_nx = S_ADD_STBY;
                    else if (configured) state_nx = S_DEL_CFG;
                    else                state_nx = S_DEL_RES;
                end
            end
            S_ADD_STBY: if (gnt) state_nx = S_ADD_CFG;
            S_ADD_CFG:  if (gnt) state_nx = S_IDLE;
            S_DEL_CFG:  if (gnt) state_nx = S_DEL_RES;
            S_DEL_RES:  if (gnt) state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        ev      = '0;
        ev.cls  = CLS_AVAIL;
        ev.fh   = fh_q;
        ev.fid  = fid_q;
        ev_req  = 1'b1;
        unique case (state)
            S_IDLE:     ev_req = 1'b0;
            S_ADD_STBY: ev.pec = PEC_RES_TO_STBY;
            S_ADD_CFG:  ev.pec = PEC_STBY_TO_CFG;
            S_DEL_CFG:  ev.pec = PEC_CFG_TO_STBYRES;
            S_DEL_RES:  ev.pec = PEC_STBY_TO_RES;
            default:    ev_req = 1'b0;
        endcase
    end

    assign busy = (state != S_IDLE);

    // R8: a plug always continues with standby-to-configured
    p_plug_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADD_STBY && gnt) |=> (state == S_ADD_CFG));
    // R9: configured-to-standby is always followed by standby-to-reserved
    p_unplug_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEL_CFG && gnt) |=> (state == S_DEL_RES));
endmodule

// File: rtl/evq_fifo.sv
module evq_fifo
    import evq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  evq_entry_t din,
    input  logic       pop,
    output evq_entry_t head,
    output logic       full,
    output logic       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    evq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign head  = mem[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    // R10: storage never written beyond its depth
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R3: nothing removed from an empty queue
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/evq_report.sv
module evq_report
    import evq_pkg::*;
(
    input  evq_entry_t        ent,
    output logic [REC_W-1:0]  rec,
    output logic [LEN_W-1:0]  len
);
    localparam int ERR_BYTES = REC_W / 8;
    localparam int AVL_BYTES = AVL_W / 8;

    always_comb begin
        rec = '0;
        len = '0;
        if (ent.cls == CLS_ERR) begin
            rec = {ent.fid, ent.fh, ent.qual, ent.addr, ent.pec};
            len = LEN_W'(ERR_BYTES);
        end else if (ent.cls == CLS_AVAIL) begin
            rec = {ent.fid, ent.fh, ent.pec, {(REC_W-AVL_W){1'b0}}};
            len = LEN_W'(AVL_BYTES);
        end
    end
endmodule

// File: rtl/fn_event_queue.sv
module fn_event_queue
    import evq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlt_req,
    input  logic [CLS_W-1:0]  xlt_class,
    input  logic [PEC_W-1:0]  xlt_pec,
    input  logic [FH_W-1:0]   xlt_fh,
    input  logic [FID_W-1:0]  xlt_fid,
    input  logic [ADDR_W-1:0] xlt_addr,
    input  logic [QUAL_W-1:0] xlt_qual,
    output logic              xlt_ack,
    input  logic              irq_req,
    input  logic [PEC_W-1:0]  irq_pec,
    input  logic [FID_W-1:0]  irq_fid,
    input  logic [ADDR_W-1:0] irq_addr,
    input  logic [QUAL_W-1:0] irq_qual,
    output logic              irq_ack,
    input  logic              plug_req,
    input  logic              plug_remove,
    input  logic              plug_configured,
    input  logic [FH_W-1:0]   plug_fh,
    input  logic [FID_W-1:0]  plug_fid,
    output logic              plug_busy,
    input  logic              pop_req,
    output logic              have_event,
    output logic              pop_valid,
    output logic              pop_status,
    output logic [CLS_W-1:0]  rpt_class,
    output logic [LEN_W-1:0]  rpt_len,
    output logic [REC_W-1:0]  rpt_rec,
    output logic              crw_notify,
    output logic              overflow,
    output logic              proto_err
);
    localparam int NSRC = 3;
    localparam int SRC_XLT = 0, SRC_IRQ = 1, SRC_PLUG = 2;

    logic [NSRC-1:0] req, gnt;
    evq_entry_t      src_ev [NSRC];
    evq_entry_t      sel_ev, head;
    logic            plug_ev_req, xlt_ok, sel_ok, push, pop, full, empty;
    logic [REC_W-1:0] head_rec;
    logic [LEN_W-1:0] head_len;

    evq_plug_seq u_plug (
        .clk(clk), .rst_n(rst_n), .start(plug_req), .remove(plug_remove),
        .configured(plug_configured), .fh_in(plug_fh), .fid_in(plug_fid),
        .gnt(gnt[SRC_PLUG]), .ev_req(plug_ev_req), .ev(src_ev[SRC_PLUG]),
        .busy(plug_busy)
    );

    assign src_ev[SRC_XLT] = '{cls: xlt_class, pec: xlt_pec, fh: xlt_fh,
                               fid: xlt_fid, addr: xlt_addr, qual: xlt_qual};
    assign src_ev[SRC_IRQ] = '{cls: CLS_ERR, pec: irq_pec, fh: '0,
                               fid: irq_fid, addr: irq_addr, qual: irq_qual};

    assign req = {plug_ev_req, irq_req, xlt_req};

    evq_arbiter #(.N(NSRC)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt)
    );

    always_comb begin
        sel_ev = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (gnt[i]) sel_ev = src_ev[i];
        end
    end

    assign xlt_ok  = (xlt_class == CLS_ERR) || (xlt_class == CLS_AVAIL);
    assign sel_ok  = gnt[SRC_XLT] ? xlt_ok : 1'b1;
    assign push    = (|gnt) && sel_ok && !full;
    assign pop     = pop_req && !empty;
    assign xlt_ack = gnt[SRC_XLT];
    assign irq_ack = gnt[SRC_IRQ];

    evq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(sel_ev), .pop(pop),
        .head(head), .full(full), .empty(empty)
    );

    evq_report u_rpt (.ent(head), .rec(head_rec), .len(head_len));

    assign have_event = !empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_valid  <= 1'b0;
            pop_status <= 1'b0;
            rpt_class  <= '0;
            rpt_len    <= '0;
            rpt_rec    <= '0;
            crw_notify <= 1'b0;
            overflow   <= 1'b0;
            proto_err  <= 1'b0;
        end else begin
            pop_valid  <= pop_req;
            crw_notify <= push;
            if (|gnt && sel_ok && full) overflow  <= 1'b1;
            if (gnt[SRC_XLT] && !xlt_ok) proto_err <= 1'b1;
            if (pop_req) begin
                pop_status <= empty;
                rpt_class  <= empty ? '0 : head.cls;
                rpt_len    <= empty ? '0 : head_len;
                rpt_rec    <= empty ? '0 : head_rec;
            end
        end
    end

    // R6: a notification only ever follows an accepted enqueue
    p_notify_r6: assert property (@(posedge clk) disable iff (!rst_n)
        crw_notify |-> $past(push));
    // R2: empty pop reports no event
    p_pop_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty) |=> (pop_valid && pop_status));
    // R10: overflow is sticky
    p_overflow_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R11: protocol error is sticky
    p_proto_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
    // R1: have_event follows a push from empty
    p_have_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> have_event);
endmodule

// File: tb/test_fn_event_queue.sv
module test_fn_event_queue;
    import evq_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic xlt_req = 0, irq_req = 0, plug_req = 0, plug_remove = 0;
    logic plug_configured = 0, pop_req = 0;
    logic [1:0]  xlt_class = 0;
    logic [15:0] xlt_pec = 0, irq_pec = 0;
    logic [31:0] xlt_fh = 0, xlt_fid = 0, xlt_qual = 0, irq_fid = 0;
    logic [31:0] irq_qual = 0, plug_fh = 0, plug_fid = 0;
    logic [63:0] xlt_addr = 0, irq_addr = 0;
    logic xlt_ack, irq_ack, plug_busy, have_event, pop_valid, pop_status;
    logic crw_notify, overflow, proto_err;
    logic [1:0]   rpt_class;
    logic [4:0]   rpt_len;
    logic [175:0] rpt_rec;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fn_event_queue #(.DEPTH(DEPTH)) i_fn_event_queue (
        .clk(clk), .rst_n(rst_n),
        .xlt_req(xlt_req), .xlt_class(xlt_class), .xlt_pec(xlt_pec),
        .xlt_fh(xlt_fh), .xlt_fid(xlt_fid), .xlt_addr(xlt_addr),
        .xlt_qual(xlt_qual), .xlt_ack(xlt_ack),
        .irq_req(irq_req), .irq_pec(irq_pec), .irq_fid(irq_fid),
        .irq_addr(irq_addr), .irq_qual(irq_qual), .irq_ack(irq_ack),
        .plug_req(plug_req), .plug_remove(plug_remove),
        .plug_configured(plug_configured), .plug_fh(plug_fh),
        .plug_fid(plug_fid), .plug_busy(plug_busy),
        .pop_req(pop_req), .have_event(have_event), .pop_valid(pop_valid),
        .pop_status(pop_status), .rpt_class(rpt_class), .rpt_len(rpt_len),
        .rpt_rec(rpt_rec), .crw_notify(crw_notify), .overflow(overflow),
        .proto_err(proto_err)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [175:0] err_rec(input logic [31:0] fid,
        input logic [31:0] fh, input logic [31:0] q, input logic [63:0] a,
        input logic [15:0] pec);
        return {fid, fh, q, a, pec};
    endfunction

    function automatic logic [175:0] avl_rec(input logic [31:0] fid,
        input logic [31:0] fh, input logic [15:0] pec);
        return {fid, fh, pec, 96'h0};
    endfunction

    // one pop; response is registered, checked one edge later
    task automatic do_pop(input logic st, input logic [1:0] cls,
                          input logic [175:0] rec, input logic [4:0] len,
                          input string tag);
        @(negedge clk) pop_req = 1'b1;
        @(negedge clk) pop_req = 1'b0;
        chk(pop_valid === 1'b1, {tag, " valid"}, 256'(pop_valid), 1);
        chk(pop_status === st, {tag, " status"}, 256'(pop_status), 256'(st));
        chk(rpt_class === cls, {tag, " class"}, 256'(rpt_class), 256'(cls));
        chk(rpt_len === len, {tag, " len"}, 256'(rpt_len), 256'(len));
        chk(rpt_rec === rec, {tag, " rec"}, 256'(rpt_rec), 256'(rec));
    endtask

    task automatic xlt_send(input logic [1:0] cls, input logic [15:0] pec,
                            input logic [31:0] fh, input logic [31:0] fid,
                            input logic [63:0] a, input logic [31:0] q,
                            input logic exp_notify, input string tag);
        @(negedge clk);
        xlt_req = 1; xlt_class = cls; xlt_pec = pec; xlt_fh = fh;
        xlt_fid = fid; xlt_addr = a; xlt_qual = q;
        #1 chk(xlt_ack === 1'b1, {tag, " R7 xlt_ack"}, 256'(xlt_ack), 1);
        @(negedge clk) xlt_req = 0;
        chk(crw_notify === exp_notify, {tag, " R6 notify"},
            256'(crw_notify), 256'(exp_notify));
    endtask

    task automatic test_reset;
        chk(have_event === 1'b0, "R1 reset have_event", 256'(have_event), 0);
        chk(crw_notify === 1'b0 && overflow === 1'b0 && proto_err === 1'b0,
            "R1 reset flags", 256'({crw_notify, overflow, proto_err}), 0);
    endtask

    task automatic test_pop_empty;
        do_pop(1'b1, 2'd0, '0, 5'd0, "R2 empty pop");
    endtask

    task automatic test_error_record;
        xlt_send(CLS_ERR, 16'h00A1, 32'h8000_0003, 32'h0000_0003,
                 64'h0123_4567_89AB_CDEF, 32'h4000_0000, 1'b1, "R4 send");
        chk(have_event === 1'b1, "R1 have after push", 256'(have_event), 1);
        @(negedge clk);
        chk(crw_notify === 1'b0, "R6 single pulse", 256'(crw_notify), 0);
        do_pop(1'b0, CLS_ERR, err_rec(32'h3, 32'h8000_0003, 32'h4000_0000,
               64'h0123_4567_89AB_CDEF, 16'h00A1), 5'd22, "R4 error rec");
        chk(have_event === 1'b0, "R3 removed", 256'(have_event), 0);
    endtask

    task automatic test_avail_record;
        xlt_send(CLS_AVAIL, 16'h0055, 32'hCAFE_0001, 32'h0000_0011,
                 64'hFFFF_0000_FFFF_0000, 32'hDEAD_BEEF, 1'b1, "R5 send");
        do_pop(1'b0, CLS_AVAIL, avl_rec(32'h11, 32'hCAFE_0001, 16'h0055),
               5'd10, "R5 avail rec");
    endtask

    task automatic test_priority_plug;
        @(negedge clk);
        xlt_req = 1; xlt_class = CLS_ERR; xlt_pec = 16'h0010;
        xlt_fh = 32'h11; xlt_fid = 32'h1; xlt_addr = 64'h1000; xlt_qual = 0;
        irq_req = 1; irq_pec = 16'h0020; irq_fid = 32'h2;
        irq_addr = 64'h2000; irq_qual = 32'h7;
        plug_req = 1; plug_remove = 0; plug_fh = 32'h8000_0005;
        plug_fid = 32'h5;
        #1 chk(xlt_ack === 1 && irq_ack === 0, "R7 xlt first",
               256'({xlt_ack, irq_ack}), 256'(2'b10));
        @(negedge clk);
        xlt_req = 0; plug_req = 0;
        #1 chk(irq_ack === 1, "R7 irq second", 256'(irq_ack), 1);
        chk(plug_busy === 1, "R8 seq busy", 256'(plug_busy), 1);
        @(negedge clk) irq_req = 0;
        repeat (3) @(negedge clk);
        chk(plug_busy === 0, "R8 seq done", 256'(plug_busy), 0);
        do_pop(1'b0, CLS_ERR, err_rec(32'h1, 32'h11, 0, 64'h1000, 16'h0010),
               5'd22, "R7 order 1");
        do_pop(1'b0, CLS_ERR, err_rec(32'h2, 32'h0, 32'h7, 64'h2000,
               16'h0020), 5'd22, "R12 irq event");
        do_pop(1'b0, CLS_AVAIL, avl_rec(32'h5, 32'h8000_0005,
               PEC_RES_TO_STBY), 5'd10, "R8 plug ev1");
        do_pop(1'b0, CLS_AVAIL, avl_rec(32'h5, 32'h8000_0005,
               PEC_STBY_TO_CFG), 5'd10, "R8 plug ev2");
        do_pop(1'b1, 2'd0, '0, 5'd0, "R3 drained");
    endtask

    task automatic test_unplug(input logic cfg, input string tag);
        @(negedge clk);
        plug_req = 1; plug_remove = 1; plug_configured = cfg;
        plug_fh = 32'h8000_0009; plug_fid = 32'h9;
        @(negedge clk) plug_req = 0;
        repeat (4) @(negedge clk);
        if (cfg)
            do_pop(1'b0, CLS_AVAIL, avl_rec(32'h9, 32'h8000_0009,
                   PEC_CFG_TO_STBYRES), 5'd10, {tag, " R9 cfg ev"});
        do_pop(1'b0, CLS_AVAIL, avl_rec(32'h9, 32'h8000_0009,
               PEC_STBY_TO_RES), 5'd10, {tag, " R9 res ev"});
        do_pop(1'b1, 2'd0, '0, 5'd0, {tag, " R9 no extra"});
    endtask

    task automatic test_bad_class;
        xlt_send(2'd3, 16'h1, 32'h1, 32'h1, 64'h1, 32'h1, 1'b0, "R11 bad");
        chk(proto_err === 1, "R11 proto_err", 256'(proto_err), 1);
        chk(have_event === 0, "R11 not stored", 256'(have_event), 0);
        xlt_send(2'd0, 16'h1, 32'h1, 32'h1, 64'h1, 32'h1, 1'b0, "R11 zero");
        chk(have_event === 0, "R11 class0 not stored", 256'(have_event), 0);
    endtask

    task automatic test_overflow;
        for (int i = 1; i <= DEPTH; i++)
            xlt_send(CLS_AVAIL, 16'h0, 32'h0, 32'(i), 64'h0, 32'h0, 1'b1,
                     "R10 fill");
        chk(overflow === 0, "R10 no overflow at full", 256'(overflow), 0);
        xlt_send(CLS_AVAIL, 16'h0, 32'h0, 32'hEE, 64'h0, 32'h0, 1'b0,
                 "R10 drop");
        chk(overflow === 1, "R10 overflow set", 256'(overflow), 1);
        for (int i = 1; i <= DEPTH; i++)
            do_pop(1'b0, CLS_AVAIL, avl_rec(32'(i), 32'h0, 16'h0), 5'd10,
                   "R10 drain");
        do_pop(1'b1, 2'd0, '0, 5'd0, "R10 dropped not stored");
        chk(overflow === 1, "R10 sticky", 256'(overflow), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset;
        test_pop_empty;
        test_error_record;
        test_avail_record;
        test_priority_plug;
        test_unplug(1'b1, "unplug cfg");
        test_unplug(1'b0, "unplug nocfg");
        test_bad_class;
        test_overflow;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule